// File: doc/BRIEF.md
# External Static-Memory Access Sequencer with Device Wait

This block runs single asynchronous read and write cycles for one chip select on an external static-memory bus. A host raises a request with an address, byte enables, a direction and write data. The sequencer then drives the chip select, the address, the byte selects and, for writes, the data bus. Each access passes through three phases: a setup phase, a strobe pulse phase and a hold phase. The read strobe or the write strobe is low only during the pulse phase. Each phase length comes from a configuration input. The host sees a one-clock acknowledge after the hold phase. A read also returns the data captured from the bus.

The external device can stretch an access with an active-low wait input. The wait input passes through a two-flop synchronizer. Only the pulse phase looks at it. A 2-bit mode selects one of three behaviours: wait ignored, a frozen pulse counter, or a ready-style extension at the end of the pulse. A write that follows a read must leave the device time to release the data bus. The block therefore counts a configurable number of turnaround cycles from the start of the read hold, and holds the write back until that count has run out. A configuration bit removes this turnaround.

Top module: `ebs_seq`

## Requirements
- R1: After reset, mem_cs_n, mem_rd_n and mem_wr_n are 1, and ack and mem_wdata_oe are 0.
- R2: With no wait in effect, an access holds mem_cs_n low for cfg_setup setup cycles, then the pulse length, then the hold length. The pulse length is cfg_pulse, with 0 treated as 1. The hold length is cfg_hold. Only the strobe that matches the direction goes low (mem_rd_n when req_we=0, mem_wr_n when req_we=1), and only during the pulse. The other strobe stays 1.
- R3: During a write, mem_wdata_oe is 1 and mem_wdata equals the request's write data in every cycle that mem_cs_n is low. During a read, mem_wdata_oe is 0.
- R4: ack is 1 for exactly one clock, in the cycle right after the last hold cycle, and mem_cs_n is 1 in that cycle. A request is accepted only while the sequencer is idle.
- R5: After a read, rsp_rdata holds the value mem_rdata had in the last pulse cycle, the one just before mem_rd_n returns to 1.
- R6: mem_addr equals the request address and mem_be_n equals the inverted request byte enables in every cycle that mem_cs_n is low.
- R7: With cfg_wmode equal to 00 or 01, mem_wait_n has no effect on any phase length.
- R8: A low mem_wait_n whose synchronized value does not reach the pulse phase (asserted while idle, or late in the pulse) leaves the pulse length unchanged.
- R9: With cfg_wmode = 10 (frozen), each cycle in which the synchronized wait is active during the pulse stops the pulse counter. A low mem_wait_n of w cycles, driven from pulse cycle d with d+3 ≤ pulse length, gives a pulse of pulse length + w.
- R10: With cfg_wmode = 11 (ready), the pulse counter runs down normally and the strobe stays low past the count while the synchronized wait is still active. With the same stimulus as R9, the pulse is d+w+3 cycles when d+3 ≤ pulse length ≤ d+w+2, and the pulse length otherwise.
- R11: With cfg_wmode = 10 or 11 and cfg_hold = 0, the hold phase lasts one cycle.
- R12: A write issued right after a read (cfg_float_opt = 0) sees max(cfg_float − hold length, 1) cycles with mem_cs_n high between the read's last hold cycle and the write's first setup cycle.
- R13: With cfg_float_opt = 1, or after a write, back-to-back accesses are separated by exactly one cycle with mem_cs_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_be | input | DW/8 | Byte enables, active high |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DW | Captured read data |
| cfg_setup | input | CW | Setup phase cycles |
| cfg_pulse | input | CW | Pulse phase cycles (0 acts as 1) |
| cfg_hold | input | CW | Hold phase cycles |
| cfg_wmode | input | 2 | Wait mode: 00/01 off, 10 frozen, 11 ready |
| cfg_float | input | CW | Read-to-write turnaround cycles |
| cfg_float_opt | input | 1 | 1 removes the turnaround |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW | Bus address |
| mem_be_n | output | DW/8 | Byte selects, active low |
| mem_wdata | output | DW | Bus write data |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_rdata | input | DW | Bus read data |
| mem_wait_n | input | 1 | Device wait, active low, asynchronous |

## Verification
The assertions assume three things. The configuration inputs stay constant from the start of an access until its turnaround count has drained. A request keeps its fields steady until ack. No access starts before a preceding wait assertion has cleared the synchronizer. The stimulus changes the configuration only after ten idle cycles. It raises a new request in the same cycle that the previous ack is seen. It releases the wait input when the hold phase begins, so no stretch carries into the next back-to-back access.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2,
    ST_HOLD  = 2'd3
  } ebs_state_e;

  localparam logic [1:0] WM_FREEZE = 2'b10;
  localparam logic [1:0] WM_READY  = 2'b11;
endpackage

// File: rtl/ebs_sync.sv
module ebs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/ebs_float.sv
module ebs_float #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          ready
);
  logic [CW-1:0] tc;

  // Counts the turnaround still owed after a read has left its hold phase.
  always_ff @(posedge clk) begin
    if (rst)             tc <= '0;
    else if (load)       tc <= load_val;
    else if (tc != '0)   tc <= tc - 1'b1;
  end

  // The idle cycle that precedes acceptance counts as one turnaround cycle.
  assign ready = (tc <= CW'(1));
endmodule

// File: rtl/ebs_seq.sv
module ebs_seq
  import ebs_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int SYNC_STAGES = 2,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rsp_rdata,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_pulse,
  input  logic [CW-1:0] cfg_hold,
  input  logic [1:0]    cfg_wmode,
  input  logic [CW-1:0] cfg_float,
  input  logic          cfg_float_opt,
  output logic          mem_cs_n,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_be_n,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_oe,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_wait_n
);
  ebs_state_e    st, nst;
  logic [CW-1:0] cnt, ncnt;
  logic          cur_we, nwe;
  logic          wait_s, wait_en, frz, rdy;
  logic [CW-1:0] hold_eff, pulse_eff, flt_val;
  logic          flt_ready, accept, cap, go_ack;

  ebs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (~mem_wait_n),
    .dout (wait_s)
  );

  assign wait_en   = cfg_wmode[1];
  assign frz       = (cfg_wmode == WM_FREEZE);
  assign rdy       = (cfg_wmode == WM_READY);
  assign hold_eff  = (wait_en && cfg_hold == '0) ? CW'(1) : cfg_hold;
  assign pulse_eff = (cfg_pulse == '0) ? CW'(1) : cfg_pulse;

  // Turnaround remaining after the read hold; the hold cycles already count.
  assign flt_val = (cur_we || cfg_float_opt || cfg_float <= hold_eff) ? '0
                                                                      : cfg_float - hold_eff;

  ebs_float #(.CW(CW)) u_float (
    .clk      (clk),
    .rst      (rst),
    .load     (go_ack),
    .load_val (flt_val),
    .ready    (flt_ready)
  );

  assign accept = (st == ST_IDLE) && req && (!req_we || cfg_float_opt || flt_ready);
  assign nwe    = (st == ST_IDLE) ? req_we : cur_we;

  always_comb begin
    nst    = st;
    ncnt   = cnt;
    cap    = 1'b0;
    go_ack = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (accept) begin
          if (cfg_setup != '0) begin
            nst  = ST_SETUP;
            ncnt = cfg_setup - 1'b1;
          end else begin
            nst  = ST_PULSE;
            ncnt = pulse_eff - 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (cnt != '0) ncnt = cnt - 1'b1;
        else begin
          nst  = ST_PULSE;
          ncnt = pulse_eff - 1'b1;
        end
      end
      ST_PULSE: begin
        if (frz && wait_s) begin
          ncnt = cnt;
        end else if (cnt != '0) begin
          ncnt = cnt - 1'b1;
        end else if (rdy && wait_s) begin
          ncnt = cnt;
        end else begin
          cap = !cur_we;
          if (hold_eff != '0) begin
            nst  = ST_HOLD;
            ncnt = hold_eff - 1'b1;
          end else begin
            nst    = ST_IDLE;
            go_ack = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cnt != '0) ncnt = cnt - 1'b1;
        else begin
          nst    = ST_IDLE;
          go_ack = 1'b1;
        end
      end
      default: nst = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      cnt          <= '0;
      cur_we       <= 1'b0;
      ack          <= 1'b0;
      rsp_rdata    <= '0;
      mem_cs_n     <= 1'b1;
      mem_rd_n     <= 1'b1;
      mem_wr_n     <= 1'b1;
      mem_addr     <= '0;
      mem_be_n     <= '1;
      mem_wdata    <= '0;
      mem_wdata_oe <= 1'b0;
    end else begin
      st           <= nst;
      cnt          <= ncnt;
      ack          <= go_ack;
      mem_cs_n     <= (nst == ST_IDLE);
      mem_rd_n     <= !((nst == ST_PULSE) && !nwe);
      mem_wr_n     <= !((nst == ST_PULSE) && nwe);
      mem_wdata_oe <= (nst != ST_IDLE) && nwe;
      if (accept) begin
        cur_we    <= req_we;
        mem_addr  <= req_addr;
        mem_be_n  <= ~req_be;
        mem_wdata <= req_wdata;
      end
      if (cap) rsp_rdata <= mem_rdata;
    end
  end
endmodule

// File: rtl/ebs_chk.sv
module ebs_chk #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 4,
  localparam int BW = DW / 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ack,
  input logic [CW-1:0] cfg_hold,
  input logic [1:0]    cfg_wmode,
  input logic [CW-1:0] cfg_float,
  input logic          cfg_float_opt,
  input logic          mem_cs_n,
  input logic          mem_rd_n,
  input logic          mem_wr_n,
  input logic [AW-1:0] mem_addr,
  input logic [BW-1:0] mem_be_n,
  input logic          mem_wdata_oe
);
  logic rd_last;
  int   gap_run;
  int   heff_i, exp_i;

  always_comb begin
    heff_i = (cfg_wmode[1] && cfg_hold == '0) ? 1 : int'(cfg_hold);
    exp_i  = (int'(cfg_float) > heff_i) ? int'(cfg_float) - heff_i : 0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_last <= 1'b0;
      gap_run <= 0;
    end else if (mem_cs_n) begin
      gap_run <= gap_run + 1;
    end else begin
      gap_run <= 0;
      rd_last <= !mem_wdata_oe;
    end
  end

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!mem_rd_n && !mem_wr_n));

  a_r2_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_n || !mem_wr_n) |-> !mem_cs_n);

  a_r4_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  a_r4_ack_idle: assert property (@(posedge clk) disable iff (rst)
    ack |-> mem_cs_n);

  a_r6_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

  a_r11_hold_min: assert property (@(posedge clk) disable iff (rst)
    (cfg_wmode[1] && ($rose(mem_rd_n) || $rose(mem_wr_n))) |-> !mem_cs_n);

  a_r12_float_gap: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_cs_n) && mem_wdata_oe && rd_last && !cfg_float_opt) |-> (gap_run >= exp_i));
endmodule

bind ebs_seq ebs_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ack           (ack),
  .cfg_hold      (cfg_hold),
  .cfg_wmode     (cfg_wmode),
  .cfg_float     (cfg_float),
  .cfg_float_opt (cfg_float_opt),
  .mem_cs_n      (mem_cs_n),
  .mem_rd_n      (mem_rd_n),
  .mem_wr_n      (mem_wr_n),
  .mem_addr      (mem_addr),
  .mem_be_n      (mem_be_n),
  .mem_wdata_oe  (mem_wdata_oe)
);

// File: tb/test_ebs_seq.sv
module test_ebs_seq;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ack;
  logic [DW-1:0] rsp_rdata;
  logic [CW-1:0] cfg_setup = '0, cfg_pulse = 4'd1, cfg_hold = '0, cfg_float = '0;
  logic [1:0]    cfg_wmode = '0;
  logic          cfg_float_opt = 1'b0;
  logic          mem_cs_n, mem_rd_n, mem_wr_n, mem_wdata_oe;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be_n;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_wait_n = 1'b1;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  ebs_seq #(.AW(AW), .DW(DW), .CW(CW)) i_ebs_seq (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .rsp_rdata(rsp_rdata),
    .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
    .cfg_wmode(cfg_wmode), .cfg_float(cfg_float), .cfg_float_opt(cfg_float_opt),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata), .mem_wait_n(mem_wait_n)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int f_peff();
    return (cfg_pulse == 0) ? 1 : int'(cfg_pulse);
  endfunction

  function automatic int f_heff();
    return (cfg_wmode[1] && cfg_hold == 0) ? 1 : int'(cfg_hold);
  endfunction

  function automatic int f_pulse(input bit drv, input int d, input int w);
    int p = f_peff();
    if (!drv || !cfg_wmode[1]) return p;
    if (cfg_wmode == 2'b10) return (d + 3 <= p) ? p + w : p;
    return (d + 3 <= p && p <= d + w + 2) ? d + w + 3 : p;
  endfunction

  function automatic int f_gap(input bit prev_rd, input bit we);
    int g;
    if (!(prev_rd && we && !cfg_float_opt)) return 1;
    g = int'(cfg_float) - f_heff();
    return (g < 1) ? 1 : g;
  endfunction

  function automatic string f_ptag(input bit drv);
    if (!cfg_wmode[1]) return "R7";
    if (!drv) return "R8";
    return (cfg_wmode == 2'b10) ? "R9" : "R10";
  endfunction

  // One access; returns at the negedge where ack is seen, with req dropped.
  task automatic run_acc(input bit we, input bit drv, input bit keep, input int d,
                         input int w, input int exp_gap, input string gtag);
    logic [AW-1:0] a  = AW'($urandom);
    logic [1:0]    be = 2'($urandom);
    logic [DW-1:0] wd = 16'($urandom);
    logic [DW-1:0] cap = '0;
    int pre = 0, su = 0, pu = 0, ho = 0, rel = -1, guard = 0;
    bit seen = 0, bad_a = 0, bad_d = 0, bad_s = 0;
    int ep = f_pulse(drv, d, w);
    int eh = f_heff();
    string ptag = f_ptag(drv);
    req = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    forever begin
      @(negedge clk);
      guard++;
      mem_rdata = 16'($urandom);
      if (ack) break;
      if (guard > 300) begin
        chk(1'b0, "R4 no ack", guard, 0);
        break;
      end
      if (!mem_cs_n) begin
        if (mem_addr !== a || mem_be_n !== ~be) bad_a = 1;
        if (we && (!mem_wdata_oe || mem_wdata !== wd)) bad_d = 1;
        if (!we && mem_wdata_oe) bad_d = 1;
        if (!(we ? mem_wr_n : mem_rd_n)) begin
          pu++;
          seen = 1;
          if (!we) cap = mem_rdata;
          if (we ? !mem_rd_n : !mem_wr_n) bad_s = 1;
        end else begin
          if (!mem_rd_n || !mem_wr_n) bad_s = 1;
          if (seen) ho++;
          else su++;
        end
      end else begin
        if (!mem_rd_n || !mem_wr_n) bad_s = 1;
        if (!seen) pre++;
      end
      if (seen) rel++;
      if (drv && seen) begin
        if (!keep && ho > 0) mem_wait_n = 1'b1;
        else mem_wait_n = !(rel >= d && rel < d + w);
      end
    end
    req = 1'b0;
    mem_wait_n = 1'b1;
    chk(mem_cs_n === 1'b1, "R4 ack cycle cs", int'(mem_cs_n), 1);
    chk(su == int'(cfg_setup), "R2 setup", su, int'(cfg_setup));
    chk(pu == ep, ptag, pu, ep);
    chk(ho == eh, (cfg_wmode[1] && cfg_hold == 0) ? "R11 hold" : "R2 hold", ho, eh);
    chk(!bad_s, "R2 strobe", int'(bad_s), 0);
    chk(!bad_a, "R6 addr/be", int'(bad_a), 0);
    chk(!bad_d, "R3 wdata", int'(bad_d), 0);
    if (!we) chk(rsp_rdata === cap, "R5 rdata", int'(rsp_rdata), int'(cap));
    if (exp_gap >= 0) chk(pre + 1 == exp_gap, gtag, pre + 1, exp_gap);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    chk(ack === 1'b0 && mem_cs_n === 1'b1, "R4 single ack", int'(ack), 0);
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic set_cfg(input int s, input int p, input int h, input int m,
                         input int f, input bit o);
    cfg_setup = CW'(s); cfg_pulse = CW'(p); cfg_hold = CW'(h);
    cfg_wmode = 2'(m); cfg_float = CW'(f); cfg_float_opt = o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R4 watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit prev_rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && mem_rd_n && mem_wr_n && !ack && !mem_wdata_oe, "R1 reset",
        int'({mem_cs_n, mem_rd_n, mem_wr_n, ack, mem_wdata_oe}), 5'b11100);

    // R2 R5: plain read, then R3: plain write
    set_cfg(2, 3, 2, 0, 0, 0);
    run_acc(1'b0, 1'b0, 1'b0, 0, 0, -1, "");
    idle(4);
    run_acc(1'b1, 1'b0, 1'b0, 0, 0, -1, "");
    idle(4);
    // R7: mode 01 ignores wait
    set_cfg(1, 4, 1, 1, 0, 0);
    run_acc(1'b0, 1'b1, 1'b0, 0, 4, -1, "");
    idle(6);
    // R9: frozen stretch 5+3
    set_cfg(1, 5, 1, 2, 0, 0);
    run_acc(1'b0, 1'b1, 1'b0, 1, 3, -1, "");
    idle(6);
    // R10: ready, window covers count end -> 7; then window too early -> 6
    set_cfg(0, 3, 1, 3, 0, 0);
    run_acc(1'b1, 1'b1, 1'b0, 0, 4, -1, "");
    idle(6);
    set_cfg(0, 6, 1, 3, 0, 0);
    run_acc(1'b0, 1'b1, 1'b0, 0, 1, -1, "");
    idle(6);
    // R11: wait enabled forces one hold cycle
    set_cfg(1, 2, 0, 3, 0, 0);
    run_acc(1'b0, 1'b0, 1'b0, 0, 0, -1, "");
    idle(6);
    // R8: wait during hold, then wait while idle
    set_cfg(2, 3, 4, 3, 0, 0);
    run_acc(1'b0, 1'b1, 1'b1, 3, 3, -1, "");
    idle(6);
    mem_wait_n = 1'b0;
    idle(5);
    mem_wait_n = 1'b1;
    idle(3);
    run_acc(1'b1, 1'b0, 1'b0, 0, 0, -1, "");
    idle(10);
    // R12: float 5, hold 1 -> 4; float 3, hold 0 -> 3
    set_cfg(1, 2, 1, 0, 5, 0);
    run_acc(1'b0, 1'b0, 1'b0, 0, 0, -1, "");
    run_acc(1'b1, 1'b0, 1'b0, 0, 0, 4, "R12 gap");
    idle(10);
    set_cfg(0, 1, 0, 0, 3, 0);
    run_acc(1'b0, 1'b0, 1'b0, 0, 0, -1, "");
    run_acc(1'b1, 1'b0, 1'b0, 0, 0, 3, "R12 gap");
    idle(10);
    // R13: optimisation on, and write after write
    set_cfg(1, 2, 1, 0, 7, 1);
    run_acc(1'b0, 1'b0, 1'b0, 0, 0, -1, "");
    run_acc(1'b1, 1'b0, 1'b0, 0, 0, 1, "R13 gap");
    set_cfg(1, 2, 1, 0, 7, 0);
    run_acc(1'b1, 1'b0, 1'b0, 0, 0, 1, "R13 gap");
    idle(10);

    // Constrained random groups of back-to-back accesses
    void'($urandom(32'd7531));
    for (int g = 0; g < 40; g++) begin
      set_cfg($urandom % 4, $urandom % 8, $urandom % 4, $urandom % 4,
              $urandom % 8, ($urandom % 4) == 0);
      idle(2);
      prev_rd = 1'b0;
      for (int k = 0; k < 4; k++) begin
        bit we  = 1'($urandom);
        bit drv = 1'($urandom);
        int d   = $urandom % f_peff();
        int w   = 1 + $urandom % 4;
        int eg  = (k == 0) ? -1 : f_gap(prev_rd, we);
        run_acc(we, drv, 1'b0, d, w, eg,
                (prev_rd && we && !cfg_float_opt) ? "R12 gap" : "R13 gap");
        prev_rd = !we;
      end
      idle(10);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule